// File: doc/BRIEF.md
# MDIO Management-Bus Master

This block is a management-bus master for Ethernet PHYs. Software sees two 32-bit registers on a simple host bus. A write to the command register, with its launch bit set, sends one complete management frame. That frame uses either the Clause 22 or the Clause 45 start pattern. A second register reports whether the engine is idle and returns the word captured by the most recent read frame. The same register also holds the MDC half-period threshold.

Every frame is 64 bit periods long and is sent most significant bit first:

- 32 preamble ones
- a 2-bit start pattern
- a 2-bit opcode
- a 5-bit port address and a 5-bit register/device address
- a 2-bit turnaround
- 16 data bits

MDC is derived from the system clock and runs only while a frame is in flight. A Clause 45 access takes two commands: software first sends an address frame, then the read or write frame.

Top module: `mdio_master`

## Requirements
- R1: After reset the engine is idle, MDC is low, `mdio_oe` is 0, the data register reads idle (bit 16 = 1) with bits 15:0 = 0, and the threshold (data bits 31:24) reads the parameter `DEF_HALF` (default 25, i.e. at most 2.5 MHz MDC from a 125 MHz clock).
- R2: A host write to offset 0x0 with bit 31 = 1 while idle launches a frame. Offset 0x0 reads bit 31 = 1 from the next cycle until the frame ends, and data bit 16 reads 0 over the same span. Bits 28:0 read back the stored command, and bits 30:29 read 0.
- R3: The frame bits are sent in this order: 32 ones; then start 01 if command bit 28 = 1, or 00 if it is 0; opcode = command bits 27:26; port = bits 25:21; register = bits 20:16; turnaround; data = bits 15:0. Each field is sent MSB first.
- R4: MDC half-period equals the threshold in system clock cycles, with a value of 0 treated as 1. MDC is low whenever the engine is idle.
- R5: MDIO output and enable change only at the system edge where MDC falls, or at the launch edge. The first preamble bit is driven from the launch edge.
- R6: A frame whose opcode bit 27 = 1 is a read frame. The master releases MDIO (`mdio_oe` = 0) from the first turnaround bit to the end of the frame. It samples `mdio_i` at each of the 16 data-bit MDC rising edges. At frame end it returns the value, first sample in bit 15, in data register bits 15:0.
- R7: A frame whose opcode bit 27 = 0 (write or address) drives turnaround 1 then 0, followed by the 16 command data bits. The stored read value is left unchanged.
- R8: While a frame is in progress, writes to offset 0x0 and to offset 0x4 are ignored. The frame continues unchanged, and the read-back command and threshold keep their old values.
- R9: A frame takes exactly 128 × threshold system cycles from the launch edge. The engine is idle again, with MDC low and MDIO released, right after the final falling edge.
- R10: `bus_rdata` is combinational from `bus_addr`. Offset 0x4 reads {threshold, 7'b0, idle, read value}, and other offsets read 0. Writes to offset 0x4 while idle load the threshold from bits 31:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Host access strobe |
| bus_we | input | 1 | Host write (1) or read (0) |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, combinational |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO pin as seen by the master |

## Verification
Every cycle, the assertions check the following:

- MDC stays low and MDIO stays released while the engine is idle.
- The preamble bits are driven ones.
- MDIO does not move while MDC is high.
- A launch puts the engine at bit 0.
- Write frames send a 1-then-0 turnaround.
- Read frames keep the pin released through turnaround and data.

Only the bench scenarios show that each field reaches the right bit period, and that frame length scales with the threshold, including the zero case. They also show that the sampled read word comes back through the data register, and that commands and threshold writes issued mid-frame leave both the wire and the read-back untouched.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam logic [5:0] IDX_LAST    = 6'd63;
  localparam logic [5:0] IDX_PRE_END = 6'd32;
  localparam logic [5:0] IDX_TA      = 6'd46;
  localparam logic [5:0] IDX_DATA    = 6'd48;

  // Assemble the serial frame, element [63] goes out first.
  function automatic logic [FRAME_BITS-1:0] build_frame(
      input logic       c22,
      input logic [1:0] op,
      input logic [4:0] port,
      input logic [4:0] regad,
      input logic [15:0] data);
    logic [1:0] st;
    logic [1:0] ta;
    st = c22 ? 2'b01 : 2'b00;
    ta = 2'b10;
    return {32'hFFFF_FFFF, st, op, port, regad, ta, data};
  endfunction

  // Opcodes with the upper bit set return data from the PHY.
  function automatic logic op_reads(input logic [1:0] op);
    return op[1];
  endfunction

  // A zero threshold behaves as one.
  function automatic logic [7:0] half_eff(input logic [7:0] thr);
    return (thr == 8'd0) ? 8'd1 : thr;
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] half,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             wrap;

  assign limit    = ((half == '0) ? ONE : half) - ONE;
  assign wrap     = run && (cnt == limit);
  assign rise_stb = wrap && !mdc;
  assign fall_stb = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + ONE;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  launch,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  rd_in,
  input  logic                  rise_stb,
  input  logic                  fall_stb,
  input  logic                  mdio_i,
  output logic                  busy,
  output logic                  rd_frame,
  output logic [5:0]            bit_idx,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  done,
  output logic [15:0]           rd_word
);
  logic [FRAME_BITS-1:0] frame_q;
  logic [15:0]           shift_q;
  logic                  in_release;

  assign done       = busy && fall_stb && (bit_idx == IDX_LAST);
  assign in_release = rd_frame && (bit_idx >= IDX_TA);
  assign mdio_o     = frame_q[IDX_LAST - bit_idx];
  assign mdio_oe    = busy && !in_release;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      rd_frame <= 1'b0;
      bit_idx  <= '0;
      frame_q  <= '0;
      shift_q  <= '0;
      rd_word  <= '0;
    end else if (launch) begin
      busy     <= 1'b1;
      rd_frame <= rd_in;
      bit_idx  <= '0;
      frame_q  <= frame_in;
    end else if (busy) begin
      if (rise_stb && bit_idx >= IDX_DATA)
        shift_q <= {shift_q[14:0], mdio_i};
      if (done) begin
        busy    <= 1'b0;
        bit_idx <= '0;
        if (rd_frame) rd_word <= shift_q;
      end else if (fall_stb) begin
        bit_idx <= bit_idx + 6'd1;
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int         ADDR_W   = 4,
  parameter logic [7:0] DEF_HALF = 8'd25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [ADDR_W-1:0] OFS_CMD  = 0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4;

  logic [28:0] cmd_q;
  logic [7:0]  thr_q;
  logic        busy, rd_frame, done;
  logic        rise_stb, fall_stb;
  logic [5:0]  bit_idx;
  logic [15:0] rd_word;
  logic        wr_cmd, wr_stat, launch;
  logic [FRAME_BITS-1:0] next_frame;

  assign wr_cmd  = bus_en && bus_we && (bus_addr == OFS_CMD);
  assign wr_stat = bus_en && bus_we && (bus_addr == OFS_STAT);
  assign launch  = wr_cmd && bus_wdata[31] && !busy;

  assign next_frame = build_frame(bus_wdata[28], bus_wdata[27:26],
                                  bus_wdata[25:21], bus_wdata[20:16],
                                  bus_wdata[15:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      thr_q <= DEF_HALF;
    end else if (!busy) begin
      if (wr_cmd)  cmd_q <= bus_wdata[28:0];
      if (wr_stat) thr_q <= bus_wdata[31:24];
    end
  end

  always_comb begin
    if (bus_addr == OFS_CMD)
      bus_rdata = {busy, 2'b00, cmd_q};
    else if (bus_addr == OFS_STAT)
      bus_rdata = {thr_q, 7'd0, !busy, rd_word};
    else
      bus_rdata = '0;
  end

  mdio_clkgen #(.CNT_W(8)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .restart  (launch),
    .half     (thr_q),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .frame_in (next_frame),
    .rd_in    (op_reads(bus_wdata[27:26])),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .rd_frame (rd_frame),
    .bit_idx  (bit_idx),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done     (done),
    .rd_word  (rd_word)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       launch,
  input logic       rd_frame,
  input logic [5:0] bit_idx,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe
);
  assert_idle_mdc_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  assert_launch_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (busy && bit_idx == 6'd0 && !mdc));

  assert_preamble_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_idx < 6'd32) |-> (mdio_oe && mdio_o));

  assert_steady_while_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_frame && bit_idx >= 6'd46) |-> !mdio_oe);

  assert_write_ta_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_frame && bit_idx == 6'd46) |-> (mdio_oe && mdio_o));

  assert_write_ta_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_frame && bit_idx == 6'd47) |-> (mdio_oe && !mdio_o));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .launch   (launch),
  .rd_frame (rd_frame),
  .bit_idx  (bit_idx),
  .mdc      (mdc),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  mdio_master dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // Behavioural reference state
  bit          m_busy;
  int          m_k, m_half;
  bit [28:0]   m_cmd;
  bit [7:0]    m_thr;
  bit [15:0]   m_rd;
  bit          m_isrd;
  bit [15:0]   phy_val;
  bit          m_bits[64];

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Lay the frame out field by field into a bit list, first element sent first.
  task automatic plan_frame(input bit [31:0] w);
    int p = 0;
    for (int i = 0; i < 32; i++) m_bits[p++] = 1'b1;
    m_bits[p++] = 1'b0;
    m_bits[p++] = w[28];
    for (int i = 27; i >= 16; i--) m_bits[p++] = w[i];
    m_bits[p++] = 1'b1;
    m_bits[p++] = 1'b0;
    for (int i = 15; i >= 0; i--) m_bits[p++] = w[i];
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_k = 0; m_cmd = '0; m_thr = 8'd25; m_rd = '0;
    end else if (m_busy) begin
      m_k++;
      if (m_k == 128 * m_half) begin
        m_busy = 0;
        if (m_isrd) m_rd = phy_val;
      end
    end else if (bus_en && bus_we) begin
      if (bus_addr == 4'd0) begin
        m_cmd = bus_wdata[28:0];
        if (bus_wdata[31]) begin
          m_busy = 1; m_k = 0;
          m_half = (m_thr == 0) ? 1 : int'(m_thr);
          m_isrd = bus_wdata[27];
          plan_frame(bus_wdata);
        end
      end else if (bus_addr == 4'd4) begin
        m_thr = bus_wdata[31:24];
      end
    end
  end

  // Per-cycle comparison of the wire and PHY response for the next edge.
  always @(negedge clk) begin
    if (rst_n) begin
      int idx;
      bit e_mdc, e_oe;
      idx   = m_busy ? m_k / (2 * m_half) : 0;
      e_mdc = m_busy ? bit'((m_k / m_half) % 2) : 1'b0;
      e_oe  = m_busy && !(m_isrd && idx >= 46);
      check("R4 R9 mdc", mdc, e_mdc);
      check("R5 R6 R7 oe", mdio_oe, e_oe);
      if (e_oe) check("R3 R5 R7 bit", mdio_o, m_bits[idx]);
      if (m_busy && idx >= 48) mdio_i = phy_val[63 - idx];
      else if (m_busy && idx == 47) mdio_i = 1'b0;
      else mdio_i = 1'b1;
    end
  end

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] cmd_word(input bit c22, input bit [1:0] op,
      input bit [4:0] port, input bit [4:0] rg, input bit [15:0] d);
    return {1'b1, 2'b00, c22, op, port, rg, d};
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 mdc", mdc, 0);
    check("R1 oe", mdio_oe, 0);
    bus_read(4'd4, r);
    check("R1 R10 status", r, {8'd25, 7'd0, 1'b1, 16'h0000});
    bus_read(4'd0, r);
    check("R1 R2 cmd", r, 0);
    bus_read(4'd8, r);
    check("R10 unmapped", r, 0);

    // Clause 22 write, threshold 2
    bus_write(4'd4, 32'h0200_0000);
    bus_write(4'd0, cmd_word(1, 2'b01, 5'h13, 5'h0A, 16'hBEEF));
    bus_read(4'd0, r);
    check("R2 busy bit", r[31], 1);
    bus_read(4'd4, r);
    check("R2 idle clear", r[16], 0);
    // R8 mid-frame writes ignored
    bus_write(4'd0, cmd_word(0, 2'b11, 5'h01, 5'h02, 16'h1234));
    bus_write(4'd4, 32'h0500_0000);
    bus_read(4'd0, r);
    check("R8 cmd kept", r[28:0], cmd_word(1, 2'b01, 5'h13, 5'h0A, 16'hBEEF) & 32'h1FFF_FFFF);
    bus_read(4'd4, r);
    check("R8 thr kept", r[31:24], 8'd2);
    wait_idle();
    bus_read(4'd0, r);
    check("R2 R9 done bit", r[31], 0);
    bus_read(4'd4, r);
    check("R7 rd untouched", r, {8'd2, 7'd0, 1'b1, 16'h0000});

    // Clause 22 read, threshold 2
    phy_val = 16'hA5C3;
    bus_write(4'd0, cmd_word(1, 2'b10, 5'h05, 5'h01, 16'h0000));
    wait_idle();
    bus_read(4'd4, r);
    check("R6 c22 read", r[15:0], 16'hA5C3);

    // Clause 45 address then read, threshold 3
    bus_write(4'd4, 32'h0300_0000);
    bus_write(4'd0, cmd_word(0, 2'b00, 5'h1F, 5'h07, 16'h8001));
    wait_idle();
    bus_read(4'd4, r);
    check("R7 addr frame keeps rd", r[15:0], 16'hA5C3);
    phy_val = 16'h0F69;
    bus_write(4'd0, cmd_word(0, 2'b11, 5'h1F, 5'h07, 16'h0000));
    wait_idle();
    bus_read(4'd4, r);
    check("R6 c45 read", r[15:0], 16'h0F69);

    // Threshold zero behaves as one, post-increment read
    bus_write(4'd4, 32'h0000_0000);
    phy_val = 16'h8000;
    bus_write(4'd0, cmd_word(0, 2'b10, 5'h00, 5'h1E, 16'hFFFF));
    wait_idle();
    bus_read(4'd4, r);
    check("R4 R6 thr0 read", r, {8'd0, 7'd0, 1'b1, 16'h8000});

    // Default threshold restored and a write frame at full length
    bus_write(4'd4, 32'h1900_0000);
    bus_write(4'd0, cmd_word(0, 2'b01, 5'h0C, 5'h03, 16'h5A5A));
    wait_idle();
    bus_read(4'd0, r);
    check("R9 idle after long", r[31], 0);
    check("R4 idle mdc", mdc, 0);

    summary();
  end
endmodule